// File: doc/BRIEF.md
# DMA Channel Count and End-Flag Controller

This block decides when one DMA channel runs and when it stops. Software writes a transfer count and then starts the channel through a control register. While the channel runs, each completed transfer unit arrives as a one-cycle strobe and lowers the remaining count by one. The count in place at start is held as a reference. When the remaining count falls to half of that reference or below, a half-way flag is raised. When the count reaches zero, an end flag is raised.

On reaching zero the channel normally stops. A mask bit can keep it running instead, and the count then reloads from the held start value. The mask is honoured only in level-sensitive external request mode and only when source or destination address reload is enabled. Four abort causes stop the channel on the next edge: non-maskable interrupt, address error, loss of the global enable, and clearing of the channel enable. Both flags clear only when zero is written to them after they have been read as one.

The block has no streaming data path. The transfer strobe, the register port and the status pins are plain single-cycle control signals, so no valid/ready handshake and no back-pressure apply.

Top module: `dma_term_ctl`

## Requirements
- R1: After reset `run`, `half_flag` and `end_flag` are 0, the count reads 0 and the control image reads 0 (mask bit 0).
- R2: A control write (`reg_sel`=1) with enable bit 0 set starts the channel when the channel is stopped, the count is nonzero, `glob_en`=1, and `nmi` and `addr_err` are both 0. `run` then reads 1 after that edge and the current count is latched as the start value. A count write (`reg_sel`=0) made while running is ignored.
- R3: Each cycle with `run`=1, `xfer_done`=1 and no abort lowers the count by one.
- R4: `half_flag` sets on the edge where the decremented count becomes less than or equal to floor(start value / 2), and not before.
- R5: When a counted strobe takes the count from 1 to 0, `end_flag` sets. In the same edge `run` falls and the count stays at 0, unless R6 applies.
- R6: With mask bit 1 set, reload bit 2 (source) or bit 3 (destination) set, and mode bits [5:4]=01 (level request), reaching the end keeps `run` at 1, sets `end_flag`, and reloads the count from the start value.
- R7: The mask has no effect in mode 00 (auto), 10 (rising edge) or 11 (falling edge), or when both reload bits are 0. In those cases the channel stops at the end.
- R8: `nmi`, `addr_err`, `glob_en`=0 or a control write with bit 0 clear forces `run` to 0 on that edge, and a strobe in the same cycle is not counted. Flags already set stay set, and an abort before the half point leaves `half_flag` at 0.
- R9: The half flag (control bit 6) and the end flag (control bit 7) clear only on a control write with that bit 0, and only after a control read (`reg_rd`, `reg_sel`=1) has returned it as 1. A zero written with no such read, or a 1 written at any time, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_sel | input | 1 | 0 selects the count, 1 selects the control register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| xfer_done | input | 1 | One transfer unit completed |
| glob_en | input | 1 | Global master enable |
| nmi | input | 1 | Non-maskable interrupt abort |
| addr_err | input | 1 | Address error abort |
| run | output | 1 | Channel running |
| half_flag | output | 1 | Half-way flag |
| end_flag | output | 1 | Transfer-end flag |

## Verification
The bench drives odd and even start counts so that the floor in the half threshold matters. If the threshold were rounded up, the half flag would rise one strobe early. The bench places aborts in the same cycle as a strobe: a design that let the strobe through would show a count one lower and could raise the half flag during the abort. The bench also walks every request mode, and the cases with and without reload, with the mask set. A design that honoured the mask too widely would keep running after the end in auto or edge mode. A design that skipped the reload would leave the count at 0. Finally, zeros are written to the flags both before and after a read, and a design without the read arming would clear them early.

// File: rtl/dma_term_pkg.sv
`timescale 1ns/1ps
package dma_term_pkg;
  typedef enum logic [1:0] {
    REQ_AUTO   = 2'b00,
    REQ_LEVEL  = 2'b01,
    REQ_EDGE_R = 2'b10,
    REQ_EDGE_F = 2'b11
  } req_mode_e;

  // control register bit positions (software-visible)
  localparam int B_EN   = 0;
  localparam int B_MASK = 1;
  localparam int B_RLS  = 2;
  localparam int B_RLD  = 3;
  localparam int B_MODE = 4;
  localparam int B_HALF = 6;
  localparam int B_END  = 7;
  localparam int CTRL_BITS = 8;

  localparam int NFLAG   = 2;
  localparam int FL_HALF = 0;
  localparam int FL_END  = 1;

  typedef struct packed {
    logic      en;
    logic      mask;
    logic      rls;
    logic      rld;
    req_mode_e mode;
  } chan_cfg_t;

  function automatic int flag_bit(input int idx);
    return (idx == FL_HALF) ? B_HALF : B_END;
  endfunction
endpackage

// File: rtl/dtc_counter.sv
`timescale 1ns/1ps
module dtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             latch,
  input  logic             step,
  input  logic             wrap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] start_cnt,
  output logic             half_hit,
  output logic             end_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_dec;
  logic [CNT_W-1:0] half_thr;

  assign cnt_dec  = cnt - ONE;
  assign half_thr = start_cnt >> 1;
  assign end_hit  = step && (cnt == ONE);
  assign half_hit = step && (cnt_dec <= half_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      start_cnt <= '0;
    end else begin
      if (latch) start_cnt <= cnt;
      if (load) begin
        cnt <= load_val;
      end else if (step) begin
        if (end_hit) cnt <= wrap ? start_cnt : '0;
        else         cnt <= cnt_dec;
      end
    end
  end
endmodule

// File: rtl/dtc_flag.sv
`timescale 1ns/1ps
module dtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_hit,
  input  logic wr_zero,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set)                   flag <= 1'b1;
      else if (armed && wr_zero) flag <= 1'b0;

      if (armed && wr_zero)      armed <= 1'b0;
      else if (rd_hit && flag)   armed <= 1'b1;
    end
  end
endmodule

// File: rtl/dtc_runctl.sv
`timescale 1ns/1ps
module dtc_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start_req,
  input  logic last_step,
  input  logic cont,
  output logic run
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  run <= 1'b0;
    else if (abort)              run <= 1'b0;
    else if (run && last_step)   run <= cont;
    else if (!run && start_req)  run <= 1'b1;
  end
endmodule

// File: rtl/dma_term_ctl.sv
`timescale 1ns/1ps
module dma_term_ctl
  import dma_term_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             xfer_done,
  input  logic             glob_en,
  input  logic             nmi,
  input  logic             addr_err,
  output logic             run,
  output logic             half_flag,
  output logic             end_flag
);
  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_q;
  logic [1:0]       mode_q;
  logic             ctrl_wr, cnt_wr, ctrl_rd;
  logic             abort, step, start_req, cont;
  logic             half_hit, end_hit;
  logic [NFLAG-1:0] flag_set, flag_q;
  logic [CTRL_BITS-1:0] ctrl_img;

  assign ctrl_wr = reg_wr && reg_sel;
  assign cnt_wr  = reg_wr && !reg_sel;
  assign ctrl_rd = reg_rd && reg_sel;

  assign abort = nmi || addr_err || !glob_en || (ctrl_wr && !reg_wdata[B_EN]);
  assign step  = run && xfer_done && !abort;
  assign start_req = ctrl_wr && reg_wdata[B_EN] && (cnt_q != '0) && !abort;
  assign cont  = cfg_q.mask && (cfg_q.rls || cfg_q.rld) && (cfg_q.mode == REQ_LEVEL);
  assign mode_q = cfg_q.mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{en: 1'b0, mask: 1'b0, rls: 1'b0, rld: 1'b0, mode: REQ_AUTO};
    end else if (ctrl_wr) begin
      cfg_q.en   <= reg_wdata[B_EN];
      cfg_q.mask <= reg_wdata[B_MASK];
      cfg_q.rls  <= reg_wdata[B_RLS];
      cfg_q.rld  <= reg_wdata[B_RLD];
      cfg_q.mode <= req_mode_e'(reg_wdata[B_MODE +: 2]);
    end
  end

  dtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_wr && !run),
    .load_val  (reg_wdata),
    .latch     (start_req && !run),
    .step      (step),
    .wrap      (cont),
    .cnt       (cnt_q),
    .start_cnt (start_q),
    .half_hit  (half_hit),
    .end_hit   (end_hit)
  );

  dtc_runctl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .start_req (start_req),
    .last_step (end_hit),
    .cont      (cont),
    .run       (run)
  );

  assign flag_set[FL_HALF] = half_hit;
  assign flag_set[FL_END]  = end_hit;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    dtc_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (flag_set[g]),
      .rd_hit  (ctrl_rd),
      .wr_zero (ctrl_wr && !reg_wdata[flag_bit(g)]),
      .flag    (flag_q[g])
    );
  end

  assign half_flag = flag_q[FL_HALF];
  assign end_flag  = flag_q[FL_END];

  always_comb begin
    ctrl_img             = '0;
    ctrl_img[B_EN]       = cfg_q.en;
    ctrl_img[B_MASK]     = cfg_q.mask;
    ctrl_img[B_RLS]      = cfg_q.rls;
    ctrl_img[B_RLD]      = cfg_q.rld;
    ctrl_img[B_MODE +: 2] = cfg_q.mode;
    ctrl_img[B_HALF]     = flag_q[FL_HALF];
    ctrl_img[B_END]      = flag_q[FL_END];
  end

  assign reg_rdata = reg_sel ? CNT_W'(ctrl_img) : cnt_q;
endmodule

// File: rtl/dma_term_chk.sv
`timescale 1ns/1ps
module dma_term_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             xfer_done,
  input logic             glob_en,
  input logic             nmi,
  input logic             addr_err,
  input logic             run,
  input logic             half_flag,
  input logic             end_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] start_q,
  input logic [1:0]       mode_q
);
  logic abrt, counted, cwr;
  assign cwr     = reg_wr && reg_sel;
  assign abrt    = nmi || addr_err || !glob_en || (cwr && !reg_wdata[0]);
  assign counted = run && xfer_done && !abrt;

  assert_run_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cwr && reg_wdata[0] && cnt_q != '0 && glob_en && !nmi && !addr_err) |=> run);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_half_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_flag && !counted) |=> !half_flag);

  assert_half_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_flag && counted && (cnt_q - CNT_W'(1)) > (start_q >> 1)) |=> !half_flag);

  assert_end_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && cnt_q == CNT_W'(1)) |=> end_flag);

  assert_mask_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && cnt_q == CNT_W'(1) && mode_q != 2'b01) |=> !run);

  assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || addr_err || !glob_en) |=> !run);

  assert_half_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (half_flag && !(cwr && !reg_wdata[6])) |=> half_flag);

  assert_end_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !(cwr && !reg_wdata[7])) |=> end_flag);
endmodule

bind dma_term_ctl dma_term_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .xfer_done (xfer_done),
  .glob_en   (glob_en),
  .nmi       (nmi),
  .addr_err  (addr_err),
  .run       (run),
  .half_flag (half_flag),
  .end_flag  (end_flag),
  .cnt_q     (cnt_q),
  .start_q   (start_q),
  .mode_q    (mode_q)
);

// File: tb/tb_dma_term_ctl.sv
`timescale 1ns/1ps
module tb_dma_term_ctl;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic xfer_done = 1'b0, glob_en = 1'b1, nmi = 1'b0, addr_err = 1'b0;
  logic run, half_flag, end_flag;

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dma_term_ctl #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .glob_en(glob_en), .nmi(nmi), .addr_err(addr_err),
    .run(run), .half_flag(half_flag), .end_flag(end_flag)
  );

  // behavioural reference model
  int m_cnt, m_start, m_mode;
  bit m_run, m_half, m_end, m_harm, m_earm, m_en, m_mask, m_rls, m_rld;

  function automatic int m_ctrl();
    return m_en | (m_mask << 1) | (m_rls << 2) | (m_rld << 3) | (m_mode << 4)
           | (m_half << 6) | (m_end << 7);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    bit cw, ab, st, cont, last, hs, wzh, wze, rdc;
    bit n_run, n_half, n_end, n_harm, n_earm;
    int n_cnt;
    if (!rst_n) begin
      m_cnt = 0; m_start = 0; m_mode = 0;
      m_run = 0; m_half = 0; m_end = 0; m_harm = 0; m_earm = 0;
      m_en = 0; m_mask = 0; m_rls = 0; m_rld = 0;
    end else begin
      cw   = reg_wr && reg_sel;
      rdc  = reg_rd && reg_sel;
      ab   = nmi || addr_err || !glob_en || (cw && !reg_wdata[0]);
      st   = m_run && xfer_done && !ab;
      cont = m_mask && (m_rls || m_rld) && (m_mode == 1);
      last = st && (m_cnt == 1);
      hs   = st && ((m_cnt - 1) <= (m_start / 2));
      wzh  = cw && !reg_wdata[6];
      wze  = cw && !reg_wdata[7];
      n_run = m_run; n_cnt = m_cnt;
      if (ab) n_run = 0;
      else if (last && !cont) n_run = 0;
      else if (!m_run && cw && reg_wdata[0] && m_cnt != 0) begin
        n_run = 1; m_start = m_cnt;
      end
      if (!m_run && reg_wr && !reg_sel) n_cnt = reg_wdata;
      else if (st) n_cnt = last ? (cont ? m_start : 0) : m_cnt - 1;
      n_half = hs ? 1 : ((m_harm && wzh) ? 0 : m_half);
      n_harm = (m_harm && wzh) ? 0 : ((rdc && m_half) ? 1 : m_harm);
      n_end  = last ? 1 : ((m_earm && wze) ? 0 : m_end);
      n_earm = (m_earm && wze) ? 0 : ((rdc && m_end) ? 1 : m_earm);
      if (cw) begin
        m_en = reg_wdata[0]; m_mask = reg_wdata[1]; m_rls = reg_wdata[2];
        m_rld = reg_wdata[3]; m_mode = reg_wdata[5:4];
      end
      m_run = n_run; m_cnt = n_cnt; m_half = n_half; m_end = n_end;
      m_harm = n_harm; m_earm = n_earm;
    end
    #1;
    if (rst_n && !finished) begin
      chk({cur_req, " model run"}, run, m_run);
      chk({cur_req, " model half"}, half_flag, m_half);
      chk({cur_req, " model end"}, end_flag, m_end);
      chk({cur_req, " model rdata"}, reg_rdata, reg_sel ? m_ctrl() : m_cnt);
    end
  end

  function automatic logic [W-1:0] cv(bit en, bit mask, bit rls, bit rld, int mode);
    return W'(en | (mask << 1) | (rls << 2) | (rld << 3) | (mode << 4));
  endfunction

  task automatic wr(bit sel, logic [W-1:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_ctrl();
    reg_rd = 1; reg_sel = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1;
      @(negedge clk);
    end
    xfer_done = 0;
  endtask

  task automatic peek(bit sel);
    reg_sel = sel; #1;
  endtask

  task automatic clear_flags();
    rd_ctrl();
    wr(1, cv(0, 0, 0, 0, 1));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 run", run, 0); chk("R1 half", half_flag, 0); chk("R1 end", end_flag, 0);
    peek(0); chk("R1 count", reg_rdata, 0);
    peek(1); chk("R1 ctrl", reg_rdata, 0);

    cur_req = "R2";
    wr(0, 10);
    wr(1, cv(1, 0, 0, 0, 1));
    chk("R2 run after start", run, 1);
    wr(0, 99);
    peek(0); chk("R2 count write ignored", reg_rdata, 10);

    cur_req = "R3";
    strobe(4);
    peek(0); chk("R3 count after 4", reg_rdata, 6);
    cur_req = "R4";
    chk("R4 half not yet", half_flag, 0);
    strobe(1);
    chk("R4 half at 5 of 10", half_flag, 1);
    cur_req = "R5";
    strobe(5);
    peek(0); chk("R5 count zero", reg_rdata, 0);
    chk("R5 end set", end_flag, 1); chk("R5 run stops", run, 0);

    cur_req = "R9";
    wr(1, cv(0, 0, 0, 0, 1));
    chk("R9 half kept without read", half_flag, 1);
    chk("R9 end kept without read", end_flag, 1);
    rd_ctrl();
    wr(1, cv(0, 0, 0, 0, 1) | W'(8'hC0));
    chk("R9 write one keeps half", half_flag, 1);
    wr(1, cv(0, 0, 0, 0, 1));
    chk("R9 half cleared", half_flag, 0); chk("R9 end cleared", end_flag, 0);

    cur_req = "R4";
    wr(0, 7);
    wr(1, cv(1, 0, 0, 0, 1));
    strobe(3);
    chk("R4 odd start: 4 > 3", half_flag, 0);
    strobe(1);
    chk("R4 odd start: 3 <= 3", half_flag, 1);
    strobe(3);
    clear_flags();

    cur_req = "R6";
    wr(0, 4);
    wr(1, cv(1, 1, 1, 0, 1));
    strobe(4);
    chk("R6 still running", run, 1); chk("R6 end set", end_flag, 1);
    peek(0); chk("R6 count reloaded", reg_rdata, 4);
    strobe(2);
    peek(0); chk("R6 second pass count", reg_rdata, 2);
    cur_req = "R8";
    wr(1, cv(0, 1, 1, 0, 1));
    chk("R8 enable-clear stops", run, 0);
    chk("R8 flags kept", end_flag & half_flag, 1);
    clear_flags();

    cur_req = "R7";
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        wr(0, 2);
        wr(1, cv(1, 1, 1, 1, m));
        strobe(2);
        chk("R7 mask ignored in mode", run, 0);
        peek(0); chk("R7 count zero", reg_rdata, 0);
        clear_flags();
      end
    end
    wr(0, 2);
    wr(1, cv(1, 1, 0, 0, 1));
    strobe(2);
    chk("R7 mask needs reload", run, 0);
    clear_flags();

    cur_req = "R8";
    wr(0, 8);
    wr(1, cv(1, 0, 0, 0, 1));
    strobe(2);
    nmi = 1; xfer_done = 1;
    @(negedge clk);
    nmi = 0; xfer_done = 0;
    chk("R8 nmi stops", run, 0);
    peek(0); chk("R8 strobe not counted", reg_rdata, 6);
    chk("R8 no half before point", half_flag, 0);
    wr(1, cv(1, 0, 0, 0, 1));
    addr_err = 1; @(negedge clk); addr_err = 0;
    chk("R8 address error stops", run, 0);
    wr(1, cv(1, 0, 0, 0, 1));
    glob_en = 0; @(negedge clk); glob_en = 1;
    chk("R8 global disable stops", run, 0);
    cur_req = "R2";
    glob_en = 0;
    wr(1, cv(1, 0, 0, 0, 1));
    glob_en = 1;
    chk("R2 no start while globally disabled", run, 0);
    cur_req = "R8";
    wr(1, cv(1, 0, 0, 0, 1));
    strobe(3);
    chk("R8 half set before abort", half_flag, 1);
    addr_err = 1; @(negedge clk); addr_err = 0;
    chk("R8 abort stops", run, 0);
    chk("R8 half stays after abort", half_flag, 1);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule